// File: doc/BRIEF.md
# Pulsed Event Interrupt Controller

This block gathers five single-cycle event strobes from an audio codec core into a sticky status register and signals the host with a low-going interrupt pulse. The low time is set by a length register and counted in system clock cycles. A per-source mask decides which events start a pulse. Masked events are still recorded, so the host can poll them.

The host reaches three registers through a simple synchronous port. Read data is combinational from the addressed register. A write takes effect at the clock edge. Reading the status register clears it at the edge that ends the read. A typical interrupt handler waits for the pin to go low, reads status once, and dispatches on the bits it finds.

Top module: `pulse_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed: bit 4 decoder frame sync, bit 3 encoder output buffer full, bit 2 encoder mute frame end, bit 1 encoder mute frame start, bit 0 encoder frame sync. These are event inputs `evt_i[4:0]` in the same order. Status bits 7..5 always read 0.
- R2: Register addresses are 0 for the mask, 1 for the pulse length and 2 for the status; address 3 reads 0. Writes to addresses 2 and 3 are ignored. After reset the mask reads 0xFF, the length reads 0x01, the status reads 0x00 and `irq_n_o` is high. Mask bits 7..5 always read 1.
- R3: A read of address 2 returns the current status and clears every status bit at the clock edge that ends the read.
- R4: An event that arrives in the same cycle as a status read is set in status after that edge, so it is not lost.
- R5: A pulse holds `irq_n_o` low for exactly N cycles, where N is the length register value sampled in the triggering cycle. It starts in the cycle after the triggering event and is followed by at least one high cycle.
- R6: While `irq_n_o` is high, an event on source k with mask bit k clear starts a pulse. An event whose mask bit is set does not start one.
- R7: Every event sets its status bit whether or not it is masked.
- R8: An event that arrives while a pulse is active is latched in status but neither lengthens nor restarts the pulse.
- R9: A length value of 0 gives a one-cycle pulse.
- R10: A mask write takes effect from the next cycle. An event in the same cycle as the write is judged against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | Event strobes, one bit per source, active high for one cycle each |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status when address is 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| irq_n_o | output | 1 | Active-low interrupt pulse |

## Verification
The properties assume that `reg_rd_i` and `reg_wr_i` are never asserted in the same cycle. They also assume that each event bit is a strobe that may recur in any cycle, including during a pulse and during a status read. The stimulus keeps reads and writes mutually exclusive. It fires sparse random events on all sources and keeps most length values small, so many pulses complete and events often land inside running pulses. Directed sequences cover a zero length, an event during a status read, and a mask write in the same cycle as an event.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask_i,
    input  logic               wr_len_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [LEN_W-1:0]   len_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [LEN_W-1:0]   len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_mask_i) cfg_d.mask = wdata_i[NUM_SRC-1:0];
        if (wr_len_i)  cfg_d.len  = wdata_i[LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask <= '1;
            cfg_q.len  <= LEN_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o = cfg_q.mask;
    assign len_o  = cfg_q.len;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] stat_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (clr_i) stat_d.bits = '0;
        // new events win over a clear in the same cycle
        stat_d.bits = stat_d.bits | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q.bits;
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             irq_n_o
);
    typedef struct packed {
        logic [LEN_W-1:0] remain;
    } pulse_t;

    pulse_t pls_d, pls_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (len_i == '0) ? LEN_W'(1) : len_i;
        pls_d   = pls_q;
        if (pls_q.remain != '0) begin
            pls_d.remain = pls_q.remain - LEN_W'(1);
        end else if (trig_i) begin
            pls_d.remain = eff_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign irq_n_o = (pls_q.remain == '0);
endmodule

// File: rtl/pulse_irq_ctrl.sv
module pulse_irq_ctrl #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_n_o
);
    import irq_pkg::*;

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] mask_w;
    logic [LEN_W-1:0]   len_w;
    logic [NUM_SRC-1:0] stat_w;
    logic               trig_w;

    always_comb begin
        if ((reg_addr_i >> 2) == '0) sel = reg_sel_e'(reg_addr_i[1:0]);
        else                         sel = SEL_NONE;
    end

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (reg_wr_i && sel == SEL_MASK),
        .wr_len_i  (reg_wr_i && sel == SEL_LEN),
        .wdata_i   (reg_wdata_i),
        .mask_o    (mask_w),
        .len_o     (len_w)
    );

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (reg_rd_i && sel == SEL_STAT),
        .stat_o (stat_w)
    );

    assign trig_w = |(evt_i & ~mask_w);

    irq_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_w),
        .len_i   (len_w),
        .irq_n_o (irq_n_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_MASK: reg_rdata_o = {{PAD_W{1'b1}}, mask_w};
            SEL_LEN:  reg_rdata_o = DATA_W'(len_w);
            SEL_STAT: reg_rdata_o = DATA_W'(stat_w);
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pulse_irq_chk.sv
module pulse_irq_chk #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned LEN_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               reg_rd_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] stat_w,
    input logic [NUM_SRC-1:0] mask_w,
    input logic [LEN_W-1:0]   len_w
);
    logic [LEN_W:0] low_run;
    logic [LEN_W:0] hold_len;
    logic           rd_stat;

    assign rd_stat = reg_rd_i && (reg_addr_i == ADDR_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            hold_len <= (LEN_W+1)'(1);
        end else begin
            low_run <= irq_n_o ? '0 : low_run + (LEN_W+1)'(1);
            if (irq_n_o)
                hold_len <= (len_w == '0) ? (LEN_W+1)'(1) : (LEN_W+1)'(len_w);
        end
    end

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(2)) |-> (reg_rdata_o[DATA_W-1:NUM_SRC] == '0));

    assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && evt_i == '0) |=> (stat_w == '0));

    assert_keep_racing_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (stat_w == $past(evt_i)));

    assert_low_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (low_run < hold_len));

    assert_full_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n_o && !$past(irq_n_o)) |-> (low_run == hold_len));

    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n_o && |(evt_i & ~mask_w)) |=> !irq_n_o);

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n_o && !(|(evt_i & ~mask_w))) |=> irq_n_o);

    assert_evt_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_w & $past(evt_i)) == $past(evt_i)));
endmodule

bind pulse_irq_ctrl pulse_irq_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_n_o     (irq_n_o),
    .stat_w      (stat_w),
    .mask_w      (mask_w),
    .len_w       (len_w)
);

// File: tb/pulse_irq_ctrl_tb.sv
module pulse_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] evt = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [4:0] m_mask;
    logic [7:0] m_len;
    logic [4:0] m_stat;
    logic [7:0] m_cnt;

    always #2 clk = ~clk;

    pulse_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {3'b111, m_mask};
            2'd1:    return m_len;
            2'd2:    return {3'b000, m_stat};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] eff_len(input logic [7:0] l);
        return (l == 8'd0) ? 8'd1 : l;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] e, input logic w, input logic r,
                        input logic [1:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        evt = e; wr = w; rd = r; addr = a; wdata = d;
        #1;
        check({7'd0, irq_n}, {7'd0, m_cnt == 8'd0}, {"R5 irq level ", tag});
        if (r) check(rdata, exp_read(a), {"read ", tag});
        // advance reference to the next edge
        if (m_cnt != 8'd0)          m_cnt = m_cnt - 8'd1;
        else if (|(e & ~m_mask))    m_cnt = eff_len(m_len);
        m_stat = ((r && a == 2'd2) ? 5'd0 : m_stat) | e;
        if (w && a == 2'd0) m_mask = d[4:0];
        if (w && a == 2'd1) m_len  = d;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(5'd0, 1'b0, 1'b0, 2'd0, 8'd0, tag);
    endtask

    initial begin
        m_mask = 5'h1F; m_len = 8'd1; m_stat = 5'd0; m_cnt = 8'd0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset values and map
        step(5'd0, 0, 1, 2'd0, 8'd0, "R2 mask reset");
        step(5'd0, 0, 1, 2'd1, 8'd0, "R2 len reset");
        step(5'd0, 0, 1, 2'd2, 8'd0, "R2 status reset");
        step(5'd0, 0, 1, 2'd3, 8'd0, "R2 unused addr");
        // masked after reset: R6 no pulse, R7 status set
        step(5'h1F, 0, 0, 2'd0, 8'd0, "R6 masked at reset");
        idle(2, "R6 masked at reset");
        step(5'd0, 0, 1, 2'd2, 8'd0, "R7 masked events recorded");
        // unmask all, R1 bit positions
        step(5'd0, 1, 0, 2'd0, 8'h00, "R2 mask write");
        for (int k = 0; k < 5; k++) begin
            step(5'd1 << k, 0, 0, 2'd0, 8'd0, "R1 source");
            idle(2, "R1 source");
            step(5'd0, 0, 1, 2'd2, 8'd0, "R1 bit position");
            step(5'd0, 0, 1, 2'd2, 8'd0, "R3 cleared after read");
        end
        // R5 length 3
        step(5'd0, 1, 0, 2'd1, 8'd3, "R5 len write");
        step(5'h01, 0, 0, 2'd0, 8'd0, "R5 trigger");
        idle(5, "R5 pulse of 3");
        // R8 events during pulse
        step(5'h02, 0, 0, 2'd0, 8'd0, "R8 trigger");
        step(5'h04, 0, 0, 2'd0, 8'd0, "R8 during pulse");
        step(5'h08, 0, 0, 2'd0, 8'd0, "R8 during pulse");
        idle(3, "R8 no extension");
        step(5'd0, 0, 1, 2'd2, 8'd0, "R8 latched during pulse");
        // R9 zero length
        step(5'd0, 1, 0, 2'd1, 8'd0, "R9 len zero");
        step(5'h10, 0, 0, 2'd0, 8'd0, "R9 trigger");
        idle(3, "R9 one cycle");
        // R4 event with read
        step(5'h05, 0, 0, 2'd0, 8'd0, "R4 setup");
        step(5'h10, 0, 1, 2'd2, 8'd0, "R4 read with event");
        step(5'd0, 0, 1, 2'd2, 8'd0, "R4 event survives");
        // R2 status write ignored
        step(5'h03, 0, 0, 2'd0, 8'd0, "R2 setup");
        step(5'd0, 1, 0, 2'd2, 8'h00, "R2 status write");
        step(5'd0, 1, 0, 2'd3, 8'hFF, "R2 unused write");
        step(5'd0, 0, 1, 2'd2, 8'd0, "R2 status unchanged");
        step(5'd0, 0, 1, 2'd3, 8'd0, "R2 unused reads zero");
        // R10 mask write races event
        idle(3, "R10 settle");
        step(5'h04, 1, 0, 2'd0, 8'h04, "R10 old mask used");
        idle(3, "R10 pulse");
        step(5'h04, 0, 0, 2'd0, 8'd0, "R10 new mask used");
        idle(3, "R10 quiet");
        step(5'd0, 0, 1, 2'd0, 8'd0, "R10 mask readback");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] e;
            int op;
            logic [7:0] d;
            e = '0;
            for (int b = 0; b < 5; b++) e[b] = ($urandom_range(0, 9) == 0);
            op = $urandom_range(0, 99);
            if (op < 25) begin
                step(e, 0, 1, 2'($urandom_range(0, 3)), 8'd0, "R3 random read");
            end else if (op < 33) begin
                int a;
                a = $urandom_range(0, 3);
                if (a == 1) d = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 6));
                else        d = 8'($urandom);
                step(e, 1, 0, 2'(a), d, "R10 random write");
            end else begin
                step(e, 0, 0, 2'd0, 8'd0, "R6 random events");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule